// File: doc/BRIEF.md
# Host Internal-Memory Access Port

This block is the slave side of a host port. Through it an external host reads and writes the on-chip program memory and data memory. The host first loads a control word with a select line and an address-latch strobe. Bit 15 of that word decides how it is used. If bit 15 is set, the word is an overlay bank selection. If bit 15 is clear, the word is a start address, and bit 14 chooses program memory or data memory. After that, the host does data reads and writes with the select line and a read or write strobe. Each data word goes to the current internal address, and the address then steps forward by one.

An acknowledge output stays high while the port is idle. It drops for as long as an accepted access is in flight. Each data word to internal memory takes one memory cycle. The port raises a request and holds it until the on-chip arbiter grants it, so the core can keep priority for as long as it needs. A program-memory word is 24 bits wide, and the host moves it in two 16-bit accesses. Data-memory writes into the control-register window at the top of the data-memory space are dropped. Overlay values outside the permitted set are still stored, but they raise an error flag.

Top module: `hmap_port`

## Requirements
- R1: After reset, host_ack is 1, mem_req is 0, pm_ovl and dm_ovl are 0, ovl_err is 0, and the address register holds data-memory address 0.
- R2: A control load (host_sel and host_latch high while host_ack is 1) with bit 15 = 1 stores bits 3:0 into pm_ovl and bits 7:4 into dm_ovl. It leaves the address and the memory-space select unchanged.
- R3: A control load with bit 15 = 0 loads bits 13:0 as the start address and bit 14 as the space select (1 = program memory, 0 = data memory). It leaves pm_ovl, dm_ovl and ovl_err unchanged.
- R4: An overlay load sets ovl_err to 1 when any of bits 14:8 is nonzero, when the program value is not 0, 4 or 5, or when the data value is not 0, 4, 5, 6 or 7. Otherwise it sets ovl_err to 0. In both cases the values are stored.
- R5: host_ack is 0 from the cycle after a data strobe is accepted until the access completes. Data strobes and control loads presented while host_ack is 0 are ignored.
- R6: A data-memory access makes exactly one memory cycle. mem_req is held, with mem_addr and mem_is_pm stable, until mem_gnt, and it drops after the granted cycle.
- R7: A data-memory write puts host_wdata on mem_wdata[15:0], with mem_wdata[23:16] = 0. A data-memory read returns mem_rdata[15:0] on host_rdata once host_ack is high again.
- R8: The address increments by one after each completed data word and wraps from 0x3FFF to 0.
- R9: A program-memory write is a pair of accesses. The first holds the upper 16 bits and makes no memory cycle. The second supplies host_wdata[7:0] and makes one memory write of {first, low byte}. The address increments only after the second access.
- R10: A program-memory read is a pair of accesses. The first makes one memory read and returns bits 23:8. The second returns {8'h00, bits 7:0} with no memory cycle. The address increments only after the second access.
- R11: A data-memory write to an address at or above 0x3FE0 makes no memory cycle and is discarded. The address still increments. Data-memory reads from that region are performed.
- R12: A control load discards a half-finished program-memory pair, so the next access is a first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host port select |
| host_latch | input | 1 | Control-word load strobe |
| host_rd | input | 1 | Data read strobe |
| host_wr | input | 1 | Data write strobe |
| host_wdata | input | 16 | Host write data or control word |
| host_rdata | output | 16 | Host read data |
| host_ack | output | 1 | High when the port can accept an access |
| mem_req | output | 1 | Internal memory cycle request |
| mem_gnt | input | 1 | Grant of the requested memory cycle |
| mem_we | output | 1 | Memory cycle is a write |
| mem_is_pm | output | 1 | Memory cycle targets program memory |
| mem_addr | output | 14 | Internal word address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid the cycle after the grant |
| pm_ovl | output | 4 | Program-memory overlay selection |
| dm_ovl | output | 4 | Data-memory overlay selection |
| ovl_err | output | 1 | Last overlay load held a value outside the permitted set |

## Verification
Assertions check the handshake on every cycle. The acknowledge is low whenever a request is up, a request stays with a stable address until its grant, a granted request lasts a single cycle, and no data-memory write request ever reaches the control-register window. They also check that the overlay fields and the address change only on the loads that own them. The bench scenarios show the data side. They cover how the two halves of a program-memory word are packed and unpacked, the increment and its wrap, dropped control-region writes, overlay error decoding, strobes that are ignored while a grant is withheld, and a control load that abandons a half-finished pair.

// File: rtl/hmap_pkg.sv
package hmap_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_CAP  = 2'd2
   } seq_st_t;

   typedef enum logic [1:0] {
      CAP_NONE  = 2'd0,
      CAP_DM    = 2'd1,
      CAP_PM_HI = 2'd2,
      CAP_PM_LO = 2'd3
   } cap_t;

endpackage

// File: rtl/hmap_ctl_latch.sv
module hmap_ctl_latch #(
   parameter int HOST_W = 16,
   parameter int ADDR_W = 14,
   parameter int OVL_W  = 4,
   parameter bit CHECK_OVL = 1'b1,
   parameter logic [(1<<OVL_W)-1:0] PM_ALLOW = 16'h0031,
   parameter logic [(1<<OVL_W)-1:0] DM_ALLOW = 16'h00F1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HOST_W-1:0] word,
   input  logic              addr_inc,
   output logic [ADDR_W-1:0] addr,
   output logic              space_pm,
   output logic [OVL_W-1:0]  pm_ovl,
   output logic [OVL_W-1:0]  dm_ovl,
   output logic              ovl_err
);

   localparam int MODE_BIT  = HOST_W - 1;
   localparam int SPACE_BIT = HOST_W - 2;
   localparam int RSV_LO    = 2 * OVL_W;
   localparam int RSV_HI    = HOST_W - 2;

   logic             is_ovl;
   logic             rsv_nz;
   logic [OVL_W-1:0] pm_val;
   logic [OVL_W-1:0] dm_val;
   logic             bad;

   assign is_ovl = word[MODE_BIT];
   assign rsv_nz = |word[RSV_HI:RSV_LO];
   assign pm_val = word[OVL_W-1:0];
   assign dm_val = word[2*OVL_W-1:OVL_W];

   generate
      if (CHECK_OVL) begin : g_ovl_check
         assign bad = rsv_nz | ~PM_ALLOW[pm_val] | ~DM_ALLOW[dm_val];
      end else begin : g_ovl_nocheck
         assign bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr     <= '0;
         space_pm <= 1'b0;
      end else if (load && !is_ovl) begin
         addr     <= word[ADDR_W-1:0];
         space_pm <= word[SPACE_BIT];
      end else if (addr_inc) begin
         addr <= addr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_ovl  <= '0;
         dm_ovl  <= '0;
         ovl_err <= 1'b0;
      end else if (load && is_ovl) begin
         pm_ovl  <= pm_val;
         dm_ovl  <= dm_val;
         ovl_err <= bad;
      end
   end

   AST_OVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && is_ovl) |=> $stable(pm_ovl) && $stable(dm_ovl) && $stable(ovl_err))
      else $error("overlay changed without overlay load"); // R2

   AST_ADDR_KEEP_ON_OVL: assert property (@(posedge clk) disable iff (!rst_n)
      (load && is_ovl && !addr_inc) |=> $stable(addr) && $stable(space_pm))
      else $error("overlay load disturbed address"); // R3

endmodule

// File: rtl/hmap_seq.sv
module hmap_seq
   import hmap_pkg::*;
#(
   parameter int HOST_W = 16,
   parameter int ADDR_W = 14,
   parameter int PM_W   = 24,
   parameter logic [ADDR_W-1:0] CTRL_BASE = 14'h3FE0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_rd,
   input  logic              dat_wr,
   input  logic [HOST_W-1:0] wdata,
   input  logic              ctl_load,
   input  logic [ADDR_W-1:0] addr,
   input  logic              space_pm,
   input  logic              mem_gnt,
   input  logic [PM_W-1:0]   mem_rdata,
   output logic              ack,
   output logic              addr_inc,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PM_W-1:0]   mem_wdata,
   output logic [HOST_W-1:0] rdata
);

   localparam int LO_W  = PM_W - HOST_W;
   localparam int PAD_W = HOST_W - LO_W;

   seq_st_t           st;
   cap_t              cap_q;
   logic              phase_q;
   logic              inc_q;
   logic [HOST_W-1:0] hi_q;
   logic [LO_W-1:0]   lo_q;
   logic              go;
   logic              in_ctrl;

   assign go      = (st == ST_IDLE) && (dat_rd || dat_wr);
   assign in_ctrl = (addr >= CTRL_BASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cap_q     <= CAP_NONE;
         phase_q   <= 1'b0;
         inc_q     <= 1'b0;
         hi_q      <= '0;
         lo_q      <= '0;
         mem_we    <= 1'b0;
         mem_wdata <= '0;
         rdata     <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (ctl_load) begin
                  phase_q <= 1'b0;
               end else if (go && dat_wr) begin
                  mem_we <= 1'b1;
                  cap_q  <= CAP_NONE;
                  if (space_pm) begin
                     if (!phase_q) begin
                        hi_q    <= wdata;
                        phase_q <= 1'b1;
                        inc_q   <= 1'b0;
                        st      <= ST_CAP;
                     end else begin
                        mem_wdata <= {hi_q, wdata[LO_W-1:0]};
                        phase_q   <= 1'b0;
                        inc_q     <= 1'b1;
                        st        <= ST_REQ;
                     end
                  end else if (in_ctrl) begin
                     inc_q <= 1'b1;
                     st    <= ST_CAP;
                  end else begin
                     mem_wdata <= {{LO_W{1'b0}}, wdata};
                     inc_q     <= 1'b1;
                     st        <= ST_REQ;
                  end
               end else if (go) begin
                  mem_we <= 1'b0;
                  if (space_pm) begin
                     if (!phase_q) begin
                        cap_q   <= CAP_PM_HI;
                        phase_q <= 1'b1;
                        inc_q   <= 1'b0;
                        st      <= ST_REQ;
                     end else begin
                        cap_q   <= CAP_PM_LO;
                        phase_q <= 1'b0;
                        inc_q   <= 1'b1;
                        st      <= ST_CAP;
                     end
                  end else begin
                     cap_q <= CAP_DM;
                     inc_q <= 1'b1;
                     st    <= ST_REQ;
                  end
               end
            end
            ST_REQ: begin
               if (mem_gnt) st <= ST_CAP;
            end
            ST_CAP: begin
               unique case (cap_q)
                  CAP_DM:    rdata <= mem_rdata[HOST_W-1:0];
                  CAP_PM_HI: begin
                     rdata <= mem_rdata[PM_W-1:LO_W];
                     lo_q  <= mem_rdata[LO_W-1:0];
                  end
                  CAP_PM_LO: rdata <= {{PAD_W{1'b0}}, lo_q};
                  default:   ;
               endcase
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ack      = (st == ST_IDLE);
   assign mem_req  = (st == ST_REQ);
   assign addr_inc = (st == ST_CAP) && inc_q;

   AST_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ack)
      else $error("ack high during request"); // R5

   AST_ACK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CAP) |=> ack)
      else $error("ack not restored after completion"); // R5

   AST_ONE_MEM_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> !mem_req)
      else $error("request beyond its granted cycle"); // R6

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> mem_req && $stable(addr) && $stable(space_pm))
      else $error("request dropped or moved before grant"); // R6

   AST_NO_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !space_pm) |-> (addr < CTRL_BASE))
      else $error("write into control-register window"); // R11

endmodule

// File: rtl/hmap_port.sv
module hmap_port #(
   parameter int HOST_W = 16,
   parameter int ADDR_W = 14,
   parameter int PM_W   = 24,
   parameter int OVL_W  = 4,
   parameter bit CHECK_OVL = 1'b1,
   parameter logic [ADDR_W-1:0] CTRL_BASE = 14'h3FE0,
   parameter logic [(1<<OVL_W)-1:0] PM_ALLOW = 16'h0031,
   parameter logic [(1<<OVL_W)-1:0] DM_ALLOW = 16'h00F1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_latch,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   output logic              host_ack,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic              mem_we,
   output logic              mem_is_pm,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PM_W-1:0]   mem_wdata,
   input  logic [PM_W-1:0]   mem_rdata,
   output logic [OVL_W-1:0]  pm_ovl,
   output logic [OVL_W-1:0]  dm_ovl,
   output logic              ovl_err
);

   generate
      if (ADDR_W > HOST_W - 2) begin : g_bad_addr_w
         initial $error("ADDR_W must leave room for mode and space bits");
      end
      if (PM_W <= HOST_W || PM_W > 2 * HOST_W) begin : g_bad_pm_w
         initial $error("PM_W must lie between HOST_W+1 and 2*HOST_W");
      end
      if (2 * OVL_W > HOST_W - 2) begin : g_bad_ovl_w
         initial $error("overlay fields overlap the mode bits");
      end
   endgenerate

   logic ctl_load;
   logic dat_rd;
   logic dat_wr;
   logic addr_inc;

   assign ctl_load = host_sel && host_latch && host_ack;
   assign dat_rd   = host_sel && host_rd && !host_wr && !host_latch;
   assign dat_wr   = host_sel && host_wr && !host_latch;

   hmap_ctl_latch #(
      .HOST_W   (HOST_W),
      .ADDR_W   (ADDR_W),
      .OVL_W    (OVL_W),
      .CHECK_OVL(CHECK_OVL),
      .PM_ALLOW (PM_ALLOW),
      .DM_ALLOW (DM_ALLOW)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ctl_load),
      .word    (host_wdata),
      .addr_inc(addr_inc),
      .addr    (mem_addr),
      .space_pm(mem_is_pm),
      .pm_ovl  (pm_ovl),
      .dm_ovl  (dm_ovl),
      .ovl_err (ovl_err)
   );

   hmap_seq #(
      .HOST_W   (HOST_W),
      .ADDR_W   (ADDR_W),
      .PM_W     (PM_W),
      .CTRL_BASE(CTRL_BASE)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .dat_rd   (dat_rd),
      .dat_wr   (dat_wr),
      .wdata    (host_wdata),
      .ctl_load (ctl_load),
      .addr     (mem_addr),
      .space_pm (mem_is_pm),
      .mem_gnt  (mem_gnt),
      .mem_rdata(mem_rdata),
      .ack      (host_ack),
      .addr_inc (addr_inc),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_wdata(mem_wdata),
      .rdata    (host_rdata)
   );

endmodule

// File: tb/hmap_port_bench.sv
`timescale 1ns/1ps
module hmap_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_latch = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        host_ack;
   logic        mem_req, mem_gnt, mem_we, mem_is_pm;
   logic [13:0] mem_addr;
   logic [23:0] mem_wdata;
   logic [23:0] mem_rdata;
   logic [3:0]  pm_ovl, dm_ovl;
   logic        ovl_err;
   logic        core_hold = 1'b0;

   logic [23:0] pm_m [64];
   logic [23:0] dm_m [64];
   int          mem_cycles = 0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   assign mem_gnt = mem_req && !core_hold;

   always @(posedge clk) begin
      if (mem_req && mem_gnt) begin
         mem_cycles <= mem_cycles + 1;
         if (mem_we) begin
            if (mem_is_pm) pm_m[mem_addr[5:0]] <= mem_wdata;
            else           dm_m[mem_addr[5:0]] <= mem_wdata;
         end
         mem_rdata <= mem_is_pm ? pm_m[mem_addr[5:0]] : dm_m[mem_addr[5:0]];
      end
   end

   hmap_port u_hmap_port (
      .clk(clk), .rst_n(rst_n),
      .host_sel(host_sel), .host_latch(host_latch), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
      .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_is_pm(mem_is_pm),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .pm_ovl(pm_ovl), .dm_ovl(dm_ovl), .ovl_err(ovl_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_ack();
      int n = 0;
      while (!host_ack && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic do_latch(input logic [15:0] w);
      @(negedge clk);
      host_sel = 1'b1; host_latch = 1'b1; host_wdata = w;
      @(negedge clk);
      host_sel = 1'b0; host_latch = 1'b0;
   endtask

   task automatic do_write(input logic [15:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_wdata = d;
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b0;
      wait_ack();
   endtask

   task automatic do_read(output logic [15:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_rd = 1'b1;
      @(negedge clk);
      host_sel = 1'b0; host_rd = 1'b0;
      wait_ack();
      d = host_rdata;
   endtask

   task automatic t_reset();
      chk("R1 ack", host_ack, 1);
      chk("R1 req", mem_req, 0);
      chk("R1 pm_ovl", pm_ovl, 0);
      chk("R1 dm_ovl", dm_ovl, 0);
      chk("R1 ovl_err", ovl_err, 0);
      chk("R1 addr", mem_addr, 0);
      chk("R1 space", mem_is_pm, 0);
   endtask

   task automatic t_overlay();
      do_latch(16'h0005);
      do_latch(16'h8054);
      chk("R2 pm_ovl", pm_ovl, 4);
      chk("R2 dm_ovl", dm_ovl, 5);
      chk("R4 err clear", ovl_err, 0);
      chk("R2 addr kept", mem_addr, 14'h0005);
      do_latch(16'h8076);
      chk("R4 bad pm stored", pm_ovl, 6);
      chk("R4 dm stored", dm_ovl, 7);
      chk("R4 err bad pm", ovl_err, 1);
      do_latch(16'h8100);
      chk("R4 err reserved", ovl_err, 1);
      do_latch(16'h8085);
      chk("R4 err bad dm", ovl_err, 1);
      do_latch(16'h8000);
      chk("R4 err cleared", ovl_err, 0);
      do_latch(16'h8074);
      do_latch(16'h0011);
      chk("R3 ovl kept", {pm_ovl, dm_ovl}, 8'h47);
      chk("R3 err kept", ovl_err, 0);
      chk("R3 addr", mem_addr, 14'h0011);
      do_write(16'hAAAA);
      chk("R2 write at kept addr", dm_m[17], 24'h00AAAA);
   endtask

   task automatic t_dm();
      int c0;
      logic [15:0] d;
      do_latch(16'h0010);
      chk("R3 space dm", mem_is_pm, 0);
      c0 = mem_cycles;
      do_write(16'h1111);
      chk("R6 one cycle", mem_cycles - c0, 1);
      do_write(16'h2222);
      chk("R7 dm word0", dm_m[16], 24'h001111);
      chk("R8 dm word1", dm_m[17], 24'h002222);
      do_latch(16'h0010);
      c0 = mem_cycles;
      do_read(d);
      chk("R7 dm read0", d, 16'h1111);
      do_read(d);
      chk("R7 dm read1", d, 16'h2222);
      chk("R6 two reads two cycles", mem_cycles - c0, 2);
   endtask

   task automatic t_pm();
      int c0;
      logic [15:0] d;
      do_latch(16'h4100);
      chk("R3 space pm", mem_is_pm, 1);
      c0 = mem_cycles;
      do_write(16'hABCD);
      chk("R9 no cycle first half", mem_cycles - c0, 0);
      chk("R9 addr held", mem_addr, 14'h0100);
      do_write(16'hFFEF);
      chk("R9 pm word", pm_m[0], 24'hABCDEF);
      chk("R9 one cycle", mem_cycles - c0, 1);
      do_write(16'h1234);
      do_write(16'h0056);
      chk("R8 pm next", pm_m[1], 24'h123456);
      do_latch(16'h4100);
      c0 = mem_cycles;
      do_read(d);
      chk("R10 hi", d, 16'hABCD);
      chk("R10 one cycle", mem_cycles - c0, 1);
      do_read(d);
      chk("R10 lo", d, 16'h00EF);
      chk("R10 no cycle second", mem_cycles - c0, 1);
      do_read(d);
      chk("R10 next hi", d, 16'h1234);
   endtask

   task automatic t_wrap();
      do_latch(16'h7FFF);
      do_write(16'h0102);
      do_write(16'h0003);
      do_write(16'h0405);
      do_write(16'h0006);
      chk("R8 top word", pm_m[63], 24'h010203);
      chk("R8 wrapped word", pm_m[0], 24'h040506);
      chk("R8 wrapped addr", mem_addr, 14'h0001);
   endtask

   task automatic t_blocked();
      int c0;
      logic [15:0] d;
      dm_m[32] = 24'h007777;
      dm_m[34] = 24'h005A5A;
      do_latch(16'h3FDF);
      do_write(16'h1234);
      chk("R11 below window", dm_m[31], 24'h001234);
      c0 = mem_cycles;
      do_write(16'h9999);
      do_write(16'h8888);
      chk("R11 no cycle", mem_cycles - c0, 0);
      chk("R11 untouched", dm_m[32], 24'h007777);
      chk("R11 addr advanced", mem_addr, 14'h3FE2);
      do_read(d);
      chk("R11 read allowed", d, 16'h5A5A);
   endtask

   task automatic t_busy();
      int c0;
      do_latch(16'h0028);
      c0 = mem_cycles;
      core_hold = 1'b1;
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_wdata = 16'hC0DE;
      @(negedge clk);
      host_wr = 1'b0; host_latch = 1'b1; host_wdata = 16'h0030;
      chk("R5 ack low", host_ack, 0);
      @(negedge clk);
      host_latch = 1'b0; host_wr = 1'b1; host_wdata = 16'hBAD0;
      chk("R6 req held", mem_req, 1);
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b0;
      chk("R5 still busy", host_ack, 0);
      chk("R6 no cycle before grant", mem_cycles - c0, 0);
      core_hold = 1'b0;
      wait_ack();
      chk("R5 latch ignored", mem_addr, 14'h0029);
      do_write(16'h600D);
      chk("R5 first write", dm_m[40], 24'h00C0DE);
      chk("R5 next write", dm_m[41], 24'h00600D);
      chk("R5 ignored write no cycle", mem_cycles - c0, 2);
   endtask

   task automatic t_phase_reset();
      int c0;
      pm_m[5] = 24'h0;
      pm_m[6] = 24'h0;
      do_latch(16'h4105);
      do_write(16'h1111);
      do_latch(16'h4106);
      c0 = mem_cycles;
      do_write(16'h2222);
      chk("R12 first half again", mem_cycles - c0, 0);
      do_write(16'h0033);
      chk("R12 pm word", pm_m[6], 24'h222233);
      chk("R12 abandoned", pm_m[5], 24'h0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         pm_m[i] = '0;
         dm_m[i] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_overlay();
      t_dm();
      t_pm();
      t_wrap();
      t_blocked();
      t_busy();
      t_phase_reset();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule